// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the combinational control that keeps a five-stage integer pipeline correct when instructions depend on one another. It takes decoded fields of the instructions in decode (ID), execute (EX), memory (MEM) and write-back (WB), plus the destination register and write enable of the three later stages. From these it drives the operand selects of the two EX-stage ALU inputs and the two ID-stage equality-compare inputs, and a single stall line. While the stall line is high, the fetch and decode registers hold their contents, EX takes a nop, and MEM and WB keep moving.

Conditional branches (beq) and jumps resolve in ID. Each is followed by one delay-slot instruction that always executes. The block turns the datapath's equality result into a taken decision and raises a jump redirect. A jump never stalls. A stall is raised only when no forwarding path can deliver the value in time: a load feeding the next instruction, or a branch whose operand is still in EX or is being loaded in MEM. An ALU result in MEM reaches the branch comparator through its own select. The register file is taken to write before it reads, so WB needs no branch path.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: An EX operand select is 2'b10 (take the EX/MEM result) when MEM is write-enabled with a nonzero destination equal to that operand's source: rs for operand A, rt for operand B.
- R2: When R1 does not apply and WB is write-enabled with a nonzero destination equal to the source, the select is 2'b01 (take MEM/WB). If both stages match, MEM wins. Otherwise the select is 2'b00 (register file).
- R3: Register 0 is never forwarded and never causes a stall.
- R4: stall is 1 when EX holds a load (major opcode 100011) that is write-enabled with a nonzero destination equal to a register the ID instruction reads. rs is read by R-type (000000), load, store (101011), addi (001000) and beq (000100). rt is read by R-type, store and beq.
- R5: No stall arises from a field the ID instruction does not read. This covers rt of addi and load, and rs of the R-type shifts with function 000000 or 000010. No stall arises from a non-load in EX, or from an EX stage that is not writing.
- R6: stall is 1 when ID holds a beq and a source of it equals a nonzero, write-enabled EX destination, whether EX holds a load or an ALU operation.
- R7: For a beq source that equals a nonzero, write-enabled MEM destination: if MEM holds a load, stall is 1. Otherwise stall stays 0 and that compare select is 1 (A for rs, B for rt).
- R8: A compare select is 0 when MEM is not writing, when its destination is 0, or when the destination differs from the source.
- R9: A jump (major opcode 000010) never stalls, and jump_go is 1 in the same cycle it sits in ID.
- R10: br_taken is 1 exactly when ID holds a beq, cmp_equal is 1 and stall is 0.
- R11: A beq source that matches only the WB destination causes no stall and no compare select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_op | input | 6 | Major opcode of the instruction in ID |
| id_rs | input | 5 | First source field of the ID instruction |
| id_rt | input | 5 | Second source field of the ID instruction |
| id_funct | input | 6 | Function field of the ID instruction |
| ex_op | input | 6 | Major opcode of the instruction in EX |
| ex_rs | input | 5 | First source field of the EX instruction |
| ex_rt | input | 5 | Second source field of the EX instruction |
| ex_dst | input | 5 | Destination register of the EX instruction |
| ex_wen | input | 1 | EX instruction writes a register |
| mem_op | input | 6 | Major opcode of the instruction in MEM |
| mem_dst | input | 5 | Destination register of the MEM instruction |
| mem_wen | input | 1 | MEM instruction writes a register |
| wb_dst | input | 5 | Destination register of the WB instruction |
| wb_wen | input | 1 | WB instruction writes a register |
| cmp_equal | input | 1 | Equality of the two ID compare operands after their selects |
| fwd_a_sel | output | 2 | EX operand A source: 00 register file, 01 MEM/WB, 10 EX/MEM |
| fwd_b_sel | output | 2 | EX operand B source, same encoding |
| cmp_a_sel | output | 1 | ID compare operand A taken from MEM stage |
| cmp_b_sel | output | 1 | ID compare operand B taken from MEM stage |
| stall | output | 1 | Hold fetch and decode, insert a nop into EX |
| br_taken | output | 1 | beq in ID resolved taken |
| jump_go | output | 1 | Jump in ID redirects fetch |

## Verification
The bench targets the over-stall cases: an addi or load whose rt matches a load in EX, a shift whose unused rs matches, a load in EX that is not writing, and an ALU result in MEM feeding a beq. A design that stalls there loses cycles, and in the MEM case it also leaves the compare select low. It also targets the under-stall cases: a beq behind an ALU op in EX, and a beq behind a load in MEM. A design that misses these compares stale values and may take a wrong branch. Further cases cover a source matching both MEM and WB, where a design that picks WB feeds an older value, and register 0 sweeps that would expose forwarding of a hard-wired zero. The remaining cases are a jump whose target bits alias a load destination, which must neither stall nor be refused, and a load-use sweep over every register number.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
   localparam int OPW = 6;
   localparam int FNW = 6;

   localparam logic [OPW-1:0] OP_RTYPE = 6'b000000;
   localparam logic [OPW-1:0] OP_JUMP  = 6'b000010;
   localparam logic [OPW-1:0] OP_BEQ   = 6'b000100;
   localparam logic [OPW-1:0] OP_ADDI  = 6'b001000;
   localparam logic [OPW-1:0] OP_LOAD  = 6'b100011;
   localparam logic [OPW-1:0] OP_STORE = 6'b101011;

   localparam logic [FNW-1:0] FN_SHL = 6'b000000;
   localparam logic [FNW-1:0] FN_SHR = 6'b000010;

   typedef enum logic [1:0] {
      SRC_RF  = 2'b00,
      SRC_WB  = 2'b01,
      SRC_MEM = 2'b10
   } fwd_src_e;

   typedef struct packed {
      logic reads_rs;
      logic reads_rt;
      logic is_beq;
      logic is_jump;
   } id_dec_t;
endpackage

// File: rtl/hzc_decode.sv
module hzc_decode
   import hzc_pkg::*;
(
   input  logic [OPW-1:0] op,
   input  logic [FNW-1:0] funct,
   output id_dec_t        dec
);
   logic rtype, shift;

   always_comb begin
      rtype        = (op == OP_RTYPE);
      shift        = rtype && ((funct == FN_SHL) || (funct == FN_SHR));
      dec.is_beq   = (op == OP_BEQ);
      dec.is_jump  = (op == OP_JUMP);
      dec.reads_rs = (rtype && !shift) || (op == OP_LOAD) || (op == OP_STORE)
                     || (op == OP_ADDI) || dec.is_beq;
      dec.reads_rt = rtype || (op == OP_STORE) || dec.is_beq;
   end
endmodule

// File: rtl/hzc_fwd_sel.sv
module hzc_fwd_sel
   import hzc_pkg::*;
#(
   parameter int RA = 5
)(
   input  logic [RA-1:0] src,
   input  logic [RA-1:0] mem_dst,
   input  logic          mem_wen,
   input  logic [RA-1:0] wb_dst,
   input  logic          wb_wen,
   output logic [1:0]    sel
);
   fwd_src_e pick;
   logic     mem_hit, wb_hit;

   always_comb begin
      mem_hit = mem_wen && (mem_dst != '0) && (mem_dst == src);
      wb_hit  = wb_wen  && (wb_dst  != '0) && (wb_dst  == src);
      if (mem_hit)     pick = SRC_MEM;
      else if (wb_hit) pick = SRC_WB;
      else             pick = SRC_RF;
      sel = pick;
   end

   always_comb begin : p_chk
      if (src == '0)
         AST_ZERO_NOT_FORWARDED: assert (sel == 2'b00) else $error("reg0 forwarded"); // R3
      AST_SEL_ENCODING: assert (sel != 2'b11) else $error("illegal select"); // R1
      if (sel == 2'b01)
         AST_MEM_BEFORE_WB: assert (!(mem_wen && mem_dst == src)) else $error("WB chosen over MEM"); // R2
   end
endmodule

// File: rtl/hzc_stall.sv
module hzc_stall
   import hzc_pkg::*;
#(
   parameter int RA        = 5,
   parameter bit BR_FWD_EN = 1'b1
)(
   input  id_dec_t       id_dec,
   input  logic [RA-1:0] id_rs,
   input  logic [RA-1:0] id_rt,
   input  logic          ex_is_load,
   input  logic [RA-1:0] ex_dst,
   input  logic          ex_wen,
   input  logic          mem_is_load,
   input  logic [RA-1:0] mem_dst,
   input  logic          mem_wen,
   output logic          cmp_a_sel,
   output logic          cmp_b_sel,
   output logic          stall
);
   logic ex_live, mem_live;
   logic ex_hit_rs, ex_hit_rt, mem_hit_rs, mem_hit_rt;
   logic load_use, beq_ex, beq_mem;

   always_comb begin
      ex_live    = ex_wen  && (ex_dst  != '0);
      mem_live   = mem_wen && (mem_dst != '0);
      ex_hit_rs  = ex_live  && id_dec.reads_rs && (ex_dst == id_rs);
      ex_hit_rt  = ex_live  && id_dec.reads_rt && (ex_dst == id_rt);
      mem_hit_rs = mem_live && (mem_dst == id_rs);
      mem_hit_rt = mem_live && (mem_dst == id_rt);
      load_use   = ex_is_load && (ex_hit_rs || ex_hit_rt);
      beq_ex     = id_dec.is_beq && (ex_hit_rs || ex_hit_rt);
   end

   generate
      if (BR_FWD_EN) begin : g_br_fwd
         always_comb begin
            beq_mem   = id_dec.is_beq && mem_is_load && (mem_hit_rs || mem_hit_rt);
            cmp_a_sel = mem_hit_rs && !mem_is_load;
            cmp_b_sel = mem_hit_rt && !mem_is_load;
         end
      end else begin : g_br_wait
         always_comb begin
            beq_mem   = id_dec.is_beq && (mem_hit_rs || mem_hit_rt);
            cmp_a_sel = 1'b0;
            cmp_b_sel = 1'b0;
         end
      end
   endgenerate

   assign stall = load_use || beq_ex || beq_mem;

   always_comb begin : p_chk
      if (cmp_a_sel || cmp_b_sel)
         AST_CMP_NOT_FROM_LOAD: assert (!mem_is_load) else $error("compare fed by load"); // R7
      if (id_dec.is_beq && mem_is_load && mem_wen && mem_dst != '0 && mem_dst == id_rs)
         AST_BEQ_LOAD_MEM_STALL: assert (stall) else $error("beq behind load not held"); // R7
   end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
   import hzc_pkg::*;
#(
   parameter int RA        = 5,
   parameter bit BR_FWD_EN = 1'b1
)(
   input  logic [5:0]    id_op,
   input  logic [RA-1:0] id_rs,
   input  logic [RA-1:0] id_rt,
   input  logic [5:0]    id_funct,
   input  logic [5:0]    ex_op,
   input  logic [RA-1:0] ex_rs,
   input  logic [RA-1:0] ex_rt,
   input  logic [RA-1:0] ex_dst,
   input  logic          ex_wen,
   input  logic [5:0]    mem_op,
   input  logic [RA-1:0] mem_dst,
   input  logic          mem_wen,
   input  logic [RA-1:0] wb_dst,
   input  logic          wb_wen,
   input  logic          cmp_equal,
   output logic [1:0]    fwd_a_sel,
   output logic [1:0]    fwd_b_sel,
   output logic          cmp_a_sel,
   output logic          cmp_b_sel,
   output logic          stall,
   output logic          br_taken,
   output logic          jump_go
);
   localparam int NOPND = 2;

   generate
      if (RA < 1 || RA > 8) begin : g_bad_ra
         $error("RA must lie in 1..8");
      end
      if (OPW != 6 || FNW != 6) begin : g_bad_op
         $error("opcode and function fields must be 6 bits");
      end
   endgenerate

   id_dec_t       dec;
   logic          ex_is_load, mem_is_load;
   logic [RA-1:0] ex_src [NOPND];
   logic [1:0]    ex_sel [NOPND];

   hzc_decode i_dec (
      .op    (id_op),
      .funct (id_funct),
      .dec   (dec)
   );

   assign ex_is_load  = (ex_op  == OP_LOAD);
   assign mem_is_load = (mem_op == OP_LOAD);
   assign ex_src[0]   = ex_rs;
   assign ex_src[1]   = ex_rt;

   generate
      for (genvar k = 0; k < NOPND; k++) begin : g_opnd
         hzc_fwd_sel #(.RA(RA)) i_sel (
            .src     (ex_src[k]),
            .mem_dst (mem_dst),
            .mem_wen (mem_wen),
            .wb_dst  (wb_dst),
            .wb_wen  (wb_wen),
            .sel     (ex_sel[k])
         );
      end
   endgenerate

   assign fwd_a_sel = ex_sel[0];
   assign fwd_b_sel = ex_sel[1];

   hzc_stall #(.RA(RA), .BR_FWD_EN(BR_FWD_EN)) i_stall (
      .id_dec      (dec),
      .id_rs       (id_rs),
      .id_rt       (id_rt),
      .ex_is_load  (ex_is_load),
      .ex_dst      (ex_dst),
      .ex_wen      (ex_wen),
      .mem_is_load (mem_is_load),
      .mem_dst     (mem_dst),
      .mem_wen     (mem_wen),
      .cmp_a_sel   (cmp_a_sel),
      .cmp_b_sel   (cmp_b_sel),
      .stall       (stall)
   );

   assign br_taken = dec.is_beq && cmp_equal && !stall;
   assign jump_go  = dec.is_jump;

   always_comb begin : p_chk
      if (id_op == OP_JUMP)
         AST_JUMP_NEVER_STALLS: assert (!stall) else $error("jump stalled"); // R9
      if (ex_op == OP_LOAD && ex_wen && ex_dst != '0 && id_op == OP_LOAD && ex_dst == id_rs)
         AST_LOAD_USE_HELD: assert (stall) else $error("load-use missed"); // R4
   end
endmodule

// File: tb/test_pipe_hazard_ctl.sv
module test_pipe_hazard_ctl;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [5:0] id_op, id_funct, ex_op, mem_op;
   logic [4:0] id_rs, id_rt, ex_rs, ex_rt, ex_dst, mem_dst, wb_dst;
   logic       ex_wen, mem_wen, wb_wen, cmp_equal;
   logic [1:0] fwd_a_sel, fwd_b_sel;
   logic       cmp_a_sel, cmp_b_sel, stall, br_taken, jump_go;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   pipe_hazard_ctl i_pipe_hazard_ctl (.*);

   localparam logic [5:0] RT = 6'b000000, JP = 6'b000010, BQ = 6'b000100;
   localparam logic [5:0] AD = 6'b001000, LW = 6'b100011, SW = 6'b101011;
   localparam logic [5:0] ADD = 6'b100000, SHL = 6'b000000;

   typedef struct packed {
      logic [3:0] rq;
      logic [5:0] iop; logic [4:0] irs; logic [4:0] irt; logic [5:0] ifn;
      logic [5:0] eop; logic [4:0] ers; logic [4:0] ert; logic [4:0] ed; logic ew;
      logic [5:0] mop; logic [4:0] md; logic mw;
      logic [4:0] wd; logic ww; logic eq;
      logic [1:0] xfa; logic [1:0] xfb; logic xca; logic xcb; logic xst; logic xbr; logic xjp;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t TBL [NV] = '{
      //  rq  iop irs irt ifn  eop ers ert ed ew  mop md mw  wd ww eq  fa fb ca cb st br jp
      '{ 3, RT, 0, 0, SHL, RT, 0, 0, 0, 0, RT, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, // R3 idle
      '{ 1, RT, 0, 0, SHL, RT, 3, 4, 9, 1, RT, 3, 1, 0, 0, 0, 2, 0, 0, 0, 0, 0, 0}, // R1
      '{ 2, RT, 0, 0, SHL, RT, 3, 4, 9, 1, RT, 4, 1, 3, 1, 0, 1, 2, 0, 0, 0, 0, 0}, // R2
      '{ 2, RT, 0, 0, SHL, RT, 3, 3, 9, 1, RT, 3, 1, 3, 1, 0, 2, 2, 0, 0, 0, 0, 0}, // R2 both
      '{ 2, RT, 0, 0, SHL, RT, 3, 4, 9, 1, RT, 3, 0, 3, 1, 0, 1, 0, 0, 0, 0, 0, 0}, // R2
      '{ 3, RT, 0, 0, SHL, RT, 0, 0, 9, 1, RT, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0}, // R3
      '{ 3, RT, 0, 0, ADD, LW, 1, 0, 0, 1, RT, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, // R3
      '{ 4, RT, 6, 7, ADD, LW, 1, 6, 6, 1, RT, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0}, // R4
      '{ 4, SW, 9, 6, 0,   LW, 1, 6, 6, 1, RT, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0}, // R4
      '{ 4, LW, 6, 0, 0,   LW, 1, 6, 6, 1, RT, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0}, // R4
      '{ 5, AD, 2, 6, 0,   LW, 1, 6, 6, 1, RT, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, // R5
      '{ 5, RT, 6, 2, SHL, LW, 1, 6, 6, 1, RT, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, // R5
      '{ 5, RT, 6, 7, ADD, RT, 1, 2, 6, 1, RT, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, // R5
      '{ 5, RT, 6, 7, ADD, LW, 1, 6, 6, 0, RT, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, // R5
      '{ 6, BQ, 5, 9, 0,   RT, 1, 2, 9, 1, RT, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0}, // R6
      '{ 6, BQ, 5, 9, 0,   LW, 1, 5, 5, 1, RT, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0}, // R6
      '{ 7, BQ, 5, 9, 0,   RT, 0, 0, 0, 0, LW, 5, 1, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0}, // R7 load
      '{ 7, BQ, 5, 9, 0,   RT, 0, 0, 0, 0, RT, 5, 1, 0, 0, 1, 0, 0, 1, 0, 0, 1, 0}, // R7 fwd A
      '{ 7, BQ, 5, 9, 0,   RT, 0, 0, 0, 0, RT, 9, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0}, // R7 fwd B
      '{ 8, BQ, 0, 9, 0,   RT, 0, 0, 0, 0, RT, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 1, 0}, // R8
      '{11, BQ, 5, 9, 0,   RT, 0, 0, 0, 0, RT, 0, 0, 9, 1, 0, 0, 0, 0, 0, 0, 0, 0}, // R11
      '{ 9, JP, 6, 6, 0,   LW, 1, 6, 6, 1, LW, 6, 1, 0, 0, 0, 0, 2, 0, 0, 0, 0, 1}, // R9
      '{10, BQ, 5, 9, 0,   RT, 0, 0, 0, 0, RT, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 0}, // R10
      '{10, BQ, 5, 9, 0,   RT, 0, 0, 0, 0, RT, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, // R10
      '{10, RT, 1, 2, ADD, RT, 0, 0, 0, 0, RT, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0}  // R10
   };

   task automatic check(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      @(negedge clk);
      id_op = v.iop; id_rs = v.irs; id_rt = v.irt; id_funct = v.ifn;
      ex_op = v.eop; ex_rs = v.ers; ex_rt = v.ert; ex_dst = v.ed; ex_wen = v.ew;
      mem_op = v.mop; mem_dst = v.md; mem_wen = v.mw;
      wb_dst = v.wd; wb_wen = v.ww; cmp_equal = v.eq;
      #4;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

   initial begin
      id_op = '0; id_rs = '0; id_rt = '0; id_funct = '0;
      ex_op = '0; ex_rs = '0; ex_rt = '0; ex_dst = '0; ex_wen = 1'b0;
      mem_op = '0; mem_dst = '0; mem_wen = 1'b0;
      wb_dst = '0; wb_wen = 1'b0; cmp_equal = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk); #4;
      // idle state: all selects on register file, no stall (R3)
      check("R3", "idle stall", int'(stall), 0);
      check("R3", "idle fwd_a", int'(fwd_a_sel), 0);
      check("R9", "idle jump_go", int'(jump_go), 0);

      for (int i = 0; i < NV; i++) begin
         string rq;
         drive(TBL[i]);
         rq = $sformatf("R%0d/v%0d", TBL[i].rq, i);
         check(rq, "fwd_a_sel", int'(fwd_a_sel), int'(TBL[i].xfa));
         check(rq, "fwd_b_sel", int'(fwd_b_sel), int'(TBL[i].xfb));
         check(rq, "cmp_a_sel", int'(cmp_a_sel), int'(TBL[i].xca));
         check(rq, "cmp_b_sel", int'(cmp_b_sel), int'(TBL[i].xcb));
         check(rq, "stall",     int'(stall),     int'(TBL[i].xst));
         check(rq, "br_taken",  int'(br_taken),  int'(TBL[i].xbr));
         check(rq, "jump_go",   int'(jump_go),   int'(TBL[i].xjp));
      end

      // R4 sweep: load in EX writing each register, add in ID reading it via rs
      for (int r = 1; r < 32; r++) begin
         vec_t v;
         v = '0;
         v.iop = RT; v.irs = 5'(r); v.irt = 5'd0; v.ifn = ADD;
         v.eop = LW; v.ed = 5'(r); v.ew = 1'b1;
         drive(v);
         check("R4", $sformatf("sweep stall r%0d", r), int'(stall), 1);
         v.ew = 1'b0;
         drive(v);
         check("R5", $sformatf("sweep no-write r%0d", r), int'(stall), 0);
      end

      // R3 sweep of forwarding with dst 0 against src 0 in both stages
      for (int k = 0; k < 2; k++) begin
         vec_t v;
         v = '0;
         v.mw = 1'b1; v.ww = 1'b1; v.mop = (k == 0) ? RT : LW;
         drive(v);
         check("R3", "zero fwd_a", int'(fwd_a_sel), 0);
         check("R3", "zero fwd_b", int'(fwd_b_sel), 0);
         check("R3", "zero cmp_a", int'(cmp_a_sel), 0);
      end

      // R9: jump with both later stages loading the aliased register
      begin
         vec_t v;
         v = '0;
         v.iop = JP; v.irs = 5'd12; v.irt = 5'd12;
         v.eop = LW; v.ed = 5'd12; v.ew = 1'b1;
         v.mop = LW; v.md = 5'd12; v.mw = 1'b1; v.eq = 1'b1;
         drive(v);
         check("R9", "jump stall", int'(stall), 0);
         check("R9", "jump_go", int'(jump_go), 1);
         check("R10", "jump not branch", int'(br_taken), 0);
      end

      done = 1'b1;
      finish_run();
   end
endmodule